// File: doc/BRIEF.md
# Prescaled Fractional Baud-Rate Generator

This block turns one input clock into a single-cycle enable, `tick16`, that fires at sixteen times a chosen serial bit rate. Two counters run in cascade. A small prescaler divides the input clock by 1, 3, 4 or 5. A second divider then divides the prescaler output by a ratio taken from a table. Some table ratios are whole numbers. Three of them are thirds (16/3, 32/3 and 58/3), and one code bypasses the second stage. For a third, the divider cycles through three output periods of unequal length, so that the average period is exact.

One 8-bit select word, written through `sel_we`/`sel_wdata`, sets the whole configuration. The top bit steers `clk_out` to carry either the raw input clock or a level version of the generated rate. A reset returns the counters to zero and clears only the steering bit; the rate fields keep their value. A serial transmitter or receiver would use `tick16` as its clock enable. When the input clock is 1.8432, 2.4576 or 3.072 MHz and the prescaler is set to ÷3, ÷4 or ÷5 respectively, the prescaler output is 614.4 kHz. The divider table then yields the common serial rates.

Top module: `bdr_gen`

## Requirements
- R1: Select bits 6:5 choose the prescaler: 00 divides by 1, 01 by 3, 10 by 4, 11 by 5. The overall period of `tick16` is the prescaler ratio times the divider ratio.
- R2: Select bits 4:0 with codes 0 to 16 (excluding 2, 4 and 6) divide the prescaler output by, in code order: 2, 4, -, 8, -, 16, -, 22, 32, 64, 128, 192, 256, 288, 352, 512, 768. Consecutive ticks are exactly that many prescaler periods apart.
- R3: Code 2 gives 16/3, code 4 gives 32/3 and code 6 gives 58/3. Each repeats three periods, counted in prescaler periods: 6,5,5 for 16/3; 11,11,10 for 32/3; 20,19,19 for 58/3. Any three consecutive periods therefore span exactly N prescaler periods.
- R4: A write restarts both counters on the clock edge that accepts it. The first tick after the write appears in the P·L-th cycle after that edge, where P is the new prescaler ratio and L is the first period of the new divisor pattern. No tick appears earlier.
- R5: Code 31 bypasses the divider, so `tick16` fires once per prescaler period.
- R6: Reserved codes 17 to 30 behave exactly like code 0 (divide by 2).
- R7: With select bit 7 at 0, `clk_out` equals `clk`. With bit 7 at 1, `clk_out` is a registered level. For an even whole-number divisor D, that level is high for P·D/2 cycles of each P·D-cycle period. Under bypass it is high for floor(P/2) of every P cycles. When the total ratio is 1, `clk_out` is `clk` again.
- R8: While `rst_n` is low, `tick16` stays low and select bit 7 is 0. Select bits 6:0 keep their value through reset, and the rate resumes after reset is released.
- R9: For a total ratio of 2 or more, `tick16` is high for one cycle per period. At a total ratio of 1, it is high every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that all counters divide |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_we | input | 1 | Write strobe for the select word |
| sel_wdata | input | 8 | Select word: bit 7 output steering, bits 6:5 prescaler, bits 4:0 divisor code |
| tick16 | output | 1 | One-cycle enable at sixteen times the bit rate |
| clk_out | output | 1 | Raw input clock or generated rate level, chosen by select bit 7 |

## Verification
Most internal faults in this block show up as a wrong distance between ticks. A miscounted prescaler or a wrong divisor entry stretches or shortens the next period, which is visible within one tick interval. A wrong phase order inside a third-ratio pattern moves the first tick after a write, and it does so within the first pattern period. A phase counter that skips or repeats a step changes the three-period sum, which is visible within three ticks. A missed restart on a write, or a rate field wiped by reset, moves the first tick after the write or the reset away from its computed cycle. A fault in the steering logic shows up on `clk_out` in the half-cycle that follows the change.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

  localparam int SEL_W  = 8;
  localparam int PSEL_W = 2;
  localparam int CODE_W = 5;
  localparam int PRE_W  = 3;
  localparam int DIV_W  = 10;
  localparam int PH_W   = 2;

  localparam logic [CODE_W-1:0] CODE_BYPASS = '1;

  typedef struct packed {
    logic [DIV_W-1:0] base;
    logic [PH_W-1:0]  extra;
    logic             bypass;
  } div_cfg_t;

  function automatic logic [PRE_W-1:0] decode_pre(input logic [PSEL_W-1:0] s);
    logic [PRE_W-1:0] r;
    case (s)
      2'd0:    r = PRE_W'(1);
      2'd1:    r = PRE_W'(3);
      2'd2:    r = PRE_W'(4);
      default: r = PRE_W'(5);
    endcase
    return r;
  endfunction

  function automatic div_cfg_t decode_div(input logic [CODE_W-1:0] code);
    div_cfg_t c;
    c.base   = DIV_W'(2);
    c.extra  = '0;
    c.bypass = 1'b0;
    case (code)
      5'd1:  c.base = DIV_W'(4);
      5'd2:  begin c.base = DIV_W'(5);  c.extra = PH_W'(1); end
      5'd3:  c.base = DIV_W'(8);
      5'd4:  begin c.base = DIV_W'(10); c.extra = PH_W'(2); end
      5'd5:  c.base = DIV_W'(16);
      5'd6:  begin c.base = DIV_W'(19); c.extra = PH_W'(1); end
      5'd7:  c.base = DIV_W'(22);
      5'd8:  c.base = DIV_W'(32);
      5'd9:  c.base = DIV_W'(64);
      5'd10: c.base = DIV_W'(128);
      5'd11: c.base = DIV_W'(192);
      5'd12: c.base = DIV_W'(256);
      5'd13: c.base = DIV_W'(288);
      5'd14: c.base = DIV_W'(352);
      5'd15: c.base = DIV_W'(512);
      5'd16: c.base = DIV_W'(768);
      CODE_BYPASS: begin c.base = DIV_W'(1); c.bypass = 1'b1; end
      default: c.base = DIV_W'(2);
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bdr_prescaler.sv
module bdr_prescaler #(
  parameter int W = bdr_pkg::PRE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  output logic         tick_o,
  output logic         level_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] last;

  always_comb begin
    last    = ratio - W'(1);
    tick_o  = (cnt_q >= last);
    level_o = (cnt_q < (ratio >> 1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bdr_divider.sv
module bdr_divider #(
  parameter int CW = bdr_pkg::DIV_W,
  parameter int PW = bdr_pkg::PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [CW-1:0] base,
  input  logic [PW-1:0] extra,
  output logic          done_o,
  output logic          level_o
);

  localparam logic [PW-1:0] PH_LAST = PW'(2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [PW-1:0] ph_q;
  logic [PW-1:0] ph_d;
  logic [CW-1:0] len;
  logic          at_end;

  always_comb begin
    len     = base + ((ph_q < extra) ? CW'(1) : CW'(0));
    at_end  = (cnt_q >= len - CW'(1));
    done_o  = step && at_end;
    level_o = (cnt_q < (len >> 1));
  end

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (restart) begin
      cnt_d = '0;
      ph_d  = '0;
    end else if (step) begin
      if (at_end) begin
        cnt_d = '0;
        ph_d  = (ph_q >= PH_LAST) ? '0 : ph_q + PW'(1);
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

endmodule

// File: rtl/bdr_gen.sv
module bdr_gen
  import bdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic             tick16,
  output logic             clk_out
);

  localparam int CFG_W = SEL_W - 1;

  logic [1:0]       rs_q;
  logic             rst_q_n;
  logic             wr_en;
  logic             steer_q;
  logic [CFG_W-1:0] cfg_q;
  logic [SEL_W-1:0] sel_q;
  logic [PRE_W-1:0] pre_ratio;
  div_cfg_t         dcfg;
  logic             pre_tick;
  logic             pre_level;
  logic             div_done;
  logic             div_level;
  logic             lvl_d;
  logic             lvl_q;
  logic             unity;

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_q_n = rs_q[1];

  assign wr_en = sel_we & rst_q_n;

  // steering bit is the only select bit that reset touches
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      steer_q <= 1'b0;
    end else if (wr_en) begin
      steer_q <= sel_wdata[SEL_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      cfg_q <= sel_wdata[CFG_W-1:0];
    end
  end

  assign sel_q = {steer_q, cfg_q};

  always_comb begin
    pre_ratio = decode_pre(cfg_q[CODE_W +: PSEL_W]);
    dcfg      = decode_div(cfg_q[CODE_W-1:0]);
    unity     = dcfg.bypass && (pre_ratio == PRE_W'(1));
  end

  bdr_prescaler #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (wr_en),
    .ratio   (pre_ratio),
    .tick_o  (pre_tick),
    .level_o (pre_level)
  );

  bdr_divider #(.CW(DIV_W), .PW(PH_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (wr_en),
    .step    (pre_tick),
    .base    (dcfg.base),
    .extra   (dcfg.extra),
    .done_o  (div_done),
    .level_o (div_level)
  );

  assign tick16 = div_done & rst_q_n;

  always_comb begin
    lvl_d = dcfg.bypass ? pre_level : div_level;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign clk_out = (steer_q && !unity) ? lvl_q : clk;

endmodule

// File: rtl/bdr_gen_chk.sv
module bdr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_q_n,
  input logic       sel_we,
  input logic [6:0] sel_wdata,
  input logic [7:0] sel_q,
  input logic       tick16,
  input logic       pre_tick
);

  // R1: with a prescaler of 3 or more, a tick is never followed by another
  a_r1_prescale_gap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (tick16 && (sel_q[6:5] != 2'b00) && !sel_we) |=> !tick16);

  // R4: the cycle after an accepted write carries no tick unless the ratio is 1
  a_r4_restart_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_we && (sel_wdata != 7'h1f)) |=> !tick16);

  // R5: under bypass the output tick follows the prescaler tick
  a_r5_bypass_follow: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel_q[4:0] == 5'h1f) |-> (tick16 == pre_tick));

  // R8: no tick while reset is applied
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !tick16);

  // R8: steering bit is zero after a reset edge
  a_r8_steer_cleared: assert property (@(posedge clk)
    !rst_n |=> !sel_q[7]);

endmodule

bind bdr_gen bdr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_q_n   (rst_q_n),
  .sel_we    (sel_we),
  .sel_wdata (sel_wdata[6:0]),
  .sel_q     (sel_q),
  .tick16    (tick16),
  .pre_tick  (pre_tick)
);

// File: tb/sim_bdr_gen.sv
module sim_bdr_gen;

  logic       clk;
  logic       rst_n;
  logic       sel_we;
  logic [7:0] sel_wdata;
  logic       tick16;
  logic       clk_out;

  int n_chk;
  int n_fail;
  int cyc;

  localparam int WDOG = 190000;

  bdr_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_we),
    .sel_wdata (sel_wdata),
    .tick16    (tick16),
    .clk_out   (clk_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected < %0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pre_of(input int p);
    case (p)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 5;
    endcase
  endfunction

  // three times the divider ratio, per divisor code
  function automatic int div3_of(input int code);
    case (code)
      0: return 6;
      1: return 12;
      2: return 16;
      3: return 24;
      4: return 32;
      5: return 48;
      6: return 58;
      7: return 66;
      8: return 96;
      9: return 192;
      10: return 384;
      11: return 576;
      12: return 768;
      13: return 864;
      14: return 1056;
      15: return 1536;
      16: return 2304;
      31: return 3;
      default: return 6;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    if (code == 31) return "R5";
    if (code == 2 || code == 4 || code == 6) return "R3";
    if (code > 16) return "R6";
    return "R2";
  endfunction

  task automatic write_sel(input logic [7:0] v);
    @(negedge clk);
    sel_we    = 1'b1;
    sel_wdata = v;
    @(negedge clk);
    sel_we    = 1'b0;
  endtask

  // write, check first tick cycle (R4) and the span of nper periods
  task automatic run_rate(input int p, input int code, input string tag);
    int k;
    int tot;
    int pr;
    int n3;
    int nper;
    int first;
    int span;
    pr    = pre_of(p);
    n3    = div3_of(code);
    nper  = (n3 % 3 == 0) ? 1 : 3;
    first = pr * ((n3 + 2) / 3);
    span  = pr * n3 * nper / 3;
    write_sel({1'b0, 2'(p), 5'(code)});
    k = 0;
    while (!tick16 && k < 20000) begin
      @(negedge clk);
      k++;
    end
    check(k == first - 1, "R4", $sformatf("first tick p=%0d code=%0d", p, code), k + 1, first);
    tot = 0;
    repeat (nper) begin
      do begin
        @(negedge clk);
        tot++;
      end while (!tick16 && tot < 60000);
    end
    check(tot == span, tag, $sformatf("span p=%0d code=%0d", p, code), tot, span);
  endtask

  task automatic duty(input logic [7:0] v, input int win, input int exp_hi, input string req);
    int hi;
    write_sel(v);
    repeat (2 * win) @(negedge clk);
    hi = 0;
    repeat (win) begin
      @(negedge clk);
      if (clk_out) hi++;
    end
    check(hi == exp_hi, req, $sformatf("clk_out high count sel=%0h", v), hi, exp_hi);
  endtask

  task automatic raw_clk(input logic [7:0] v, input string req);
    write_sel(v);
    @(negedge clk);
    check(clk_out == 1'b0, req, "raw clk_out low phase", int'(clk_out), 0);
    @(posedge clk);
    #1;
    check(clk_out == 1'b1, req, "raw clk_out high phase", int'(clk_out), 1);
  endtask

  initial begin
    int tot;
    int hi;
    n_chk     = 0;
    n_fail    = 0;
    cyc       = 0;
    rst_n     = 1'b0;
    sel_we    = 1'b0;
    sel_wdata = '0;
    repeat (3) @(negedge clk);
    check(tick16 == 1'b0, "R8", "tick16 in reset", int'(tick16), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: prescaler alone, divisor 2
    for (int p = 0; p < 4; p++) run_rate(p, 0, "R1");

    // R2 R3 R5: every defined code with every prescaler
    for (int code = 0; code < 18; code++) begin
      int c;
      c = (code == 17) ? 31 : code;
      for (int p = 0; p < 4; p++) run_rate(p, c, tag_of(c));
    end

    // R6: reserved codes act as divide by 2
    run_rate(1, 20, "R6");
    run_rate(0, 30, "R6");

    // R9: one-cycle pulse at ratio 3, continuous at ratio 1
    write_sel({1'b0, 2'd1, 5'd31});
    while (!tick16) @(negedge clk);
    @(negedge clk);
    check(tick16 == 1'b0, "R9", "tick16 after pulse", int'(tick16), 0);
    write_sel({1'b0, 2'd0, 5'd31});
    hi = 0;
    repeat (4) begin
      if (tick16) hi++;
      @(negedge clk);
    end
    check(hi == 4, "R9", "ticks at unity ratio", hi, 4);

    // R7: output steering and level duty
    raw_clk({1'b0, 2'd2, 5'd0}, "R7");
    raw_clk({1'b1, 2'd0, 5'd31}, "R7");
    duty({1'b1, 2'd2, 5'd0}, 8, 4, "R7");
    duty({1'b1, 2'd0, 5'd5}, 16, 8, "R7");
    duty({1'b1, 2'd1, 5'd31}, 3, 1, "R7");
    duty({1'b1, 2'd3, 5'd31}, 5, 2, "R7");

    // R8: reset clears steering, keeps rate fields
    write_sel({1'b1, 2'd2, 5'd0});
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(tick16 == 1'b0, "R8", "tick16 during reset", int'(tick16), 0);
    @(posedge clk);
    #1;
    check(clk_out == 1'b1, "R8", "clk_out raw during reset", int'(clk_out), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!tick16) @(negedge clk);
    tot = 0;
    do begin
      @(negedge clk);
      tot++;
    end while (!tick16 && tot < 1000);
    check(tot == 8, "R8", "period after reset", tot, 8);
    hi = 0;
    repeat (8) begin
      @(negedge clk);
      if (clk_out) hi++;
    end
    check(hi == 0, "R8", "clk_out raw after reset (high at negedge)", hi, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule